// File: doc/BRIEF.md
# Flash Status Register with Sticky Errors

This block holds the eight status bits of a flash controller and presents them to a host read port. The write state machine raises and lowers bits through per-bit set and clear request vectors. It also reports suspend, resume and command-sequence-error events. A host-issued Clear Status command is the only way, apart from reset, to lower the error bits. Because the state machine cannot clear those bits, failures from several operations accumulate until software clears them. This lets a run of programs or erases be checked once at the end.

The host reads through active-low chip-enable and output-enable strobes, which are sampled on the block clock. The snapshot machine has two states. SNAP_IDLE holds while either strobe is high. The transition CAPTURE, from SNAP_IDLE to SNAP_HOLD, fires on the first clock edge at which both strobes are low. It therefore follows whichever strobe fell later, and it copies the live status into a snapshot register. SNAP_HOLD then drives the 16-bit read word and holds it unchanged, whatever the status does, for as long as both strobes stay low. The transition RELEASE, from SNAP_HOLD back to SNAP_IDLE, fires when either strobe rises. A fresh value therefore needs a strobe toggle.

Bit layout: 7 ready (1) / busy (0), 6 erase suspended, 5 erase error, 4 program error, 3 supply-low abort, 2 program suspended, 1 locked-sector abort, 0 reserved.

Top module: `fsr_top`

## Requirements
- R1: After reset the status is 80h, the snapshot machine is in SNAP_IDLE, rd_drive is 0 and rd_data is 0000h. The first read returns 0080h.
- R2: A 1 on any bit of wsm_set sets status bits 7 to 1 on the next clock. Bit 0 always reads 0, even when wsm_set[0] is 1.
- R3: wsm_clr lowers only bits 7, 6 and 2. Clear requests on bits 5, 4, 3, 1 and 0 have no effect.
- R4: clr_cmd lowers bits 5, 4, 3 and 1 and leaves bits 7, 6 and 2 unchanged.
- R5: seq_err sets bits 5, 4, 3 and 1 together.
- R6: susp_erase sets bits 7 and 6. susp_prog sets bits 7 and 2.
- R7: resume lowers bit 2 if it is set. Otherwise it lowers bit 6. In both cases it touches only that one bit.
- R8: When a set and a clear of the same bit arrive in one cycle, from any source, the set wins.
- R9: CAPTURE happens only at a clock edge where ce_n and oe_n are both low. If one strobe is already low, nothing is captured until the other one falls. The snapshot is the status as it was before that edge, and it stays constant through SNAP_HOLD.
- R10: In SNAP_HOLD, rd_drive is 1 and rd_data is {00h, snapshot}. In SNAP_IDLE, rd_drive is 0 and rd_data is 0000h.
- R11: Status changes made during SNAP_HOLD become visible only after RELEASE and a new CAPTURE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wsm_set | input | 8 | Per-bit set requests from the state machine |
| wsm_clr | input | 8 | Per-bit clear requests (honoured on bits 7, 6, 2) |
| clr_cmd | input | 1 | Clear Status command pulse |
| seq_err | input | 1 | Command-sequence-error pulse |
| susp_erase | input | 1 | Erase suspend taken |
| susp_prog | input | 1 | Program suspend taken |
| resume | input | 1 | Resume issued |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 16 | Read word, upper byte zero |
| rd_drive | output | 1 | Read word is valid and driven |

## Verification
The hardest case is a status update that lands while a read is held. It needs a strobe pair held low across a state-machine request. It also needs a CAPTURE that follows the later of two staggered strobe falls. The stimulus lowers oe_n alone for several cycles and confirms that nothing is driven. It then lowers ce_n, and while the snapshot is held it applies clear requests. It checks that the word does not move until the strobes are released and lowered again. Nested suspends, with a program suspend inside an erase suspend, are set up so that resume order can be checked one bit at a time.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int STAT_W = 8;

    localparam int B_RDY  = 7;
    localparam int B_ESUS = 6;
    localparam int B_EERR = 5;
    localparam int B_PERR = 4;
    localparam int B_VLOW = 3;
    localparam int B_PSUS = 2;
    localparam int B_LOCK = 1;

    localparam logic [STAT_W-1:0] RST_VAL    = 8'h80;
    localparam logic [STAT_W-1:0] M_LIVE     = 8'hFE;
    localparam logic [STAT_W-1:0] M_WSM_CLR  = (8'h1 << B_RDY) | (8'h1 << B_ESUS) | (8'h1 << B_PSUS);
    localparam logic [STAT_W-1:0] M_ERR      = (8'h1 << B_EERR) | (8'h1 << B_PERR) |
                                               (8'h1 << B_VLOW) | (8'h1 << B_LOCK);
    localparam logic [STAT_W-1:0] M_ESUS_SET = (8'h1 << B_RDY) | (8'h1 << B_ESUS);
    localparam logic [STAT_W-1:0] M_PSUS_SET = (8'h1 << B_RDY) | (8'h1 << B_PSUS);

    typedef enum logic [0:0] {
        SNAP_IDLE = 1'b0,
        SNAP_HOLD = 1'b1
    } snap_st_e;
endpackage

// File: rtl/fsr_bits.sv
module fsr_bits
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] wsm_set,
    input  logic [STAT_W-1:0] wsm_clr,
    input  logic              clr_cmd,
    input  logic              seq_err,
    input  logic              susp_erase,
    input  logic              susp_prog,
    input  logic              resume,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] stat_d;

    // Clear rights: state machine on its own bits, command on error bits,
    // resume on the innermost active suspend bit.
    always_comb begin
        clr_vec = wsm_clr & M_WSM_CLR;
        if (clr_cmd) begin
            clr_vec = clr_vec | M_ERR;
        end
        if (resume) begin
            if (stat_q[B_PSUS]) begin
                clr_vec[B_PSUS] = 1'b1;
            end else begin
                clr_vec[B_ESUS] = 1'b1;
            end
        end
    end

    always_comb begin
        set_vec = wsm_set;
        if (seq_err)    set_vec = set_vec | M_ERR;
        if (susp_erase) set_vec = set_vec | M_ESUS_SET;
        if (susp_prog)  set_vec = set_vec | M_PSUS_SET;
        set_vec = set_vec & M_LIVE;
    end

    // Set wins over clear.
    assign stat_d = (stat_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= RST_VAL;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;

    // R3 / R4: error bits never fall without the clear command.
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cmd |=> ((stat_q & M_ERR) & $past(stat_q & M_ERR)) == $past(stat_q & M_ERR));

    // R5: sequence error raises all four error bits.
    a_r5_seqerr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> ((stat_q & M_ERR) == M_ERR));

    // R6: erase suspend raises ready and erase-suspended.
    a_r6_erase_susp: assert property (@(posedge clk) disable iff (!rst_n)
        susp_erase |=> (stat_q[B_RDY] && stat_q[B_ESUS]));

    // R6: program suspend raises ready and program-suspended.
    a_r6_prog_susp: assert property (@(posedge clk) disable iff (!rst_n)
        susp_prog |=> (stat_q[B_RDY] && stat_q[B_PSUS]));

    // R7: resume with program suspended leaves erase-suspended untouched.
    a_r7_resume_inner: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && stat_q[B_PSUS] && !susp_prog && wsm_set[B_PSUS] == 1'b0 && wsm_clr[B_ESUS] == 1'b0)
        |=> (!stat_q[B_PSUS] && stat_q[B_ESUS] == $past(stat_q[B_ESUS] | susp_erase | wsm_set[B_ESUS])));

    // R2: reserved bit stays low.
    a_r2_bit0_low: assert property (@(posedge clk) disable iff (!rst_n)
        wsm_set[0] |=> !stat_q[0]);
endmodule

// File: rtl/fsr_snap.sv
module fsr_snap
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [STAT_W-1:0] stat,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    localparam int PAD_W = DATA_W - STAT_W;

    snap_st_e          state_q;
    snap_st_e          state_d;
    logic [STAT_W-1:0] snap_q;
    logic              both_low;
    logic              capture;

    assign both_low = !ce_n && !oe_n;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            SNAP_IDLE: begin
                if (both_low) begin
                    state_d = SNAP_HOLD;
                    capture = 1'b1;
                end
            end
            SNAP_HOLD: begin
                if (!both_low) begin
                    state_d = SNAP_IDLE;
                end
            end
            default: state_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SNAP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (capture) begin
            snap_q <= stat;
        end
    end

    always_comb begin
        rd_drive = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            SNAP_IDLE: ;
            SNAP_HOLD: begin
                rd_drive = 1'b1;
                rd_data  = {{PAD_W{1'b0}}, snap_q};
            end
            default: ;
        endcase
    end

    // R9: entering hold needs both strobes low at that edge.
    a_r9_capture_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_IDLE && !(!ce_n && !oe_n)) |=> state_q == SNAP_IDLE);

    // R9 / R11: snapshot frozen across consecutive hold cycles.
    a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_HOLD && !ce_n && !oe_n) |=> $stable(snap_q));

    // R10: upper byte of a driven word is zero.
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> rd_data[DATA_W-1:STAT_W] == '0);
endmodule

// File: rtl/fsr_top.sv
module fsr_top
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        wsm_set,
    input  logic [7:0]        wsm_clr,
    input  logic              clr_cmd,
    input  logic              seq_err,
    input  logic              susp_erase,
    input  logic              susp_prog,
    input  logic              resume,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    logic [STAT_W-1:0] stat;

    fsr_bits u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .wsm_set    (wsm_set),
        .wsm_clr    (wsm_clr),
        .clr_cmd    (clr_cmd),
        .seq_err    (seq_err),
        .susp_erase (susp_erase),
        .susp_prog  (susp_prog),
        .resume     (resume),
        .stat       (stat)
    );

    fsr_snap #(.DATA_W(DATA_W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .stat     (stat),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    // R1: nothing is driven in the cycle right after reset.
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !rd_drive);
endmodule

// File: tb/fsr_top_tb_top.sv
module fsr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  wsm_set = '0;
    logic [7:0]  wsm_clr = '0;
    logic        clr_cmd = 1'b0;
    logic        seq_err = 1'b0;
    logic        susp_erase = 1'b0;
    logic        susp_prog = 1'b0;
    logic        resume = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] rd_data;
    logic        rd_drive;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'h80;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       prev_drive = 1'b0;

    always #10 clk = ~clk;

    fsr_top dut_i (
        .clk(clk), .rst_n(rst_n), .wsm_set(wsm_set), .wsm_clr(wsm_clr),
        .clr_cmd(clr_cmd), .seq_err(seq_err), .susp_erase(susp_erase),
        .susp_prog(susp_prog), .resume(resume), .ce_n(ce_n), .oe_n(oe_n),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: each new driven word is compared against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rd_drive && !prev_drive) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", {rd_drive, rd_data}, 17'h0);
            end else begin
                check(tag_q.pop_front(), {1'b1, rd_data}, {1'b1, 8'h00, exp_q.pop_front()});
            end
        end
        prev_drive = rd_drive;
    end

    // Model built from the requirements: clears first, sets win.
    function automatic logic [7:0] next_model(input logic [7:0] m, input logic [7:0] s,
        input logic [7:0] c, input logic cmd, input logic se, input logic es,
        input logic ps, input logic rs);
        logic [7:0] n;
        n = m & ~(c & 8'hC4);
        if (cmd) n = n & 8'hC5;
        if (rs) begin
            if (m[2]) n[2] = 1'b0;
            else      n[6] = 1'b0;
        end
        n = n | (s & 8'hFE);
        if (se) n = n | 8'h3A;
        if (es) n = n | 8'hC0;
        if (ps) n = n | 8'h84;
        return n;
    endfunction

    task automatic step(input logic [7:0] s, input logic [7:0] c, input logic cmd,
        input logic se, input logic es, input logic ps, input logic rs);
        wsm_set = s; wsm_clr = c; clr_cmd = cmd; seq_err = se;
        susp_erase = es; susp_prog = ps; resume = rs;
        model = next_model(model, s, c, cmd, se, es, ps, rs);
        @(negedge clk);
        wsm_set = '0; wsm_clr = '0; clr_cmd = 0; seq_err = 0;
        susp_erase = 0; susp_prog = 0; resume = 0;
    endtask

    task automatic read_open(input string tag);
        exp_q.push_back(model);
        tag_q.push_back(tag);
        ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_close();
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_word(input string tag);
        read_open(tag);
        read_close();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {rd_drive, rd_data}, 17'h0);
        read_word("R1 reset value");
        check("R10 idle after release", {rd_drive, rd_data}, 17'h0);

        step(8'hFF, 8'h00, 0, 0, 0, 0, 0);
        read_word("R2 set all, bit0 stays low");
        step(8'h00, 8'hFF, 0, 0, 0, 0, 0);
        read_word("R3 only bits 7,6,2 cleared");
        step(8'h00, 8'h00, 1, 0, 0, 0, 0);
        read_word("R4 clear command");
        step(8'h80, 8'h00, 0, 0, 0, 0, 0);
        step(8'h00, 8'h00, 0, 1, 0, 0, 0);
        read_word("R5 sequence error");
        step(8'h44, 8'h00, 0, 0, 0, 0, 0);
        step(8'h00, 8'h00, 1, 0, 0, 0, 0);
        read_word("R4 command keeps 7,6,2");
        step(8'h00, 8'hC4, 0, 0, 0, 0, 0);
        step(8'h00, 8'h00, 0, 0, 1, 0, 0);
        read_word("R6 erase suspend");
        step(8'h00, 8'h00, 0, 0, 0, 1, 0);
        read_word("R6 program suspend nested");
        step(8'h00, 8'h00, 0, 0, 0, 0, 1);
        read_word("R7 resume clears program suspend first");
        step(8'h00, 8'h00, 0, 0, 0, 0, 1);
        read_word("R7 resume then clears erase suspend");
        step(8'h10, 8'h00, 1, 0, 0, 0, 0);
        step(8'h40, 8'h40, 0, 0, 0, 0, 0);
        read_word("R8 set beats clear");

        // Staggered strobes: oe_n first, ce_n later.
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 no capture on one strobe", {rd_drive, rd_data}, 17'h0);
        exp_q.push_back(model);
        tag_q.push_back("R9 capture on later edge");
        ce_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 held word", {rd_drive, rd_data}, {1'b1, 8'h00, 8'hD0});
        step(8'h00, 8'hC4, 0, 0, 0, 0, 0);
        @(negedge clk);
        check("R11 frozen during hold", {rd_drive, rd_data}, {1'b1, 8'h00, 8'hD0});
        read_close();
        check("R10 released", {rd_drive, rd_data}, 17'h0);
        read_word("R11 new value after toggle");

        check("R10 scoreboard drained", {16'h0, exp_q.size() == 0}, 17'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule